// File: doc/BRIEF.md
# Low-Power Seconds Counter with Alarm and Trust Lifecycle

This peripheral keeps wall time as a 32-bit whole-seconds count plus a sub-second fraction. Both advance on a slow, free-running low-power clock that is asynchronous to the host. A host on a fast clock reaches the block through a simple word-addressed register port.

The stored time is trusted only after a three-step lifecycle: init, then non-valid, then valid. The host first loads a fixed key into a supply-glitch register, then requests each exit in turn through control bits. Counting is allowed only in the valid state, and only while the key stays intact. An alarm compare register sets a sticky flag when the seconds count matches it. That flag drives a level interrupt and a wake output, each gated by control enables.

All architectural state lives in the slow domain. Host writes pass through a toggle handshake and land a few slow cycles later. A write issued while an earlier one is still in flight is discarded. Host reads return a fast-domain shadow that is refreshed once per slow cycle, while the slow registers are stable. A read therefore never mixes old and new bits.

Top module: `slow_rtc`

## Requirements
- R1: After reset every register reads 0, and `irq` and `wake` are low.
- R2: Word addresses: 0 = seconds, 1 = sub-second (read-only, low SUB_W bits), 2 = alarm, 4 = control, 5 = status, 6 = glitch key.
  - Only control bits 15, 14, 11, 7, 4 and 3 are stored; the others read 0, so writing 0xFFFF reads back 0xC898.
- R3: A host write is not visible to a read on the next host cycle. It is applied at the third slow-clock edge after the host write edge at the latest, and it reads back soon after that.
- R4: With the glitch key equal to 0x41736166 and control bit 15 set, the block leaves init and status bit 15 sets. With any other key it stays in init and status bit 15 stays 0.
- R5: Control bit 14 moves the block from non-valid to valid and sets status bit 14. The request is ignored while still in init, and status bit 14 then stays 0.
- R6: When the key differs from 0x41736166 outside init, the block falls back to non-valid, status bit 14 clears and counting stops. Restoring the key with control bit 14 still set re-enters valid.
- R7: The counter runs only in the valid state with control bit 3 set. The sub-second field steps once per slow cycle, and its rollover increments the seconds count.
- R8: A write to the seconds register loads that value and clears the sub-second field.
- R9: The seconds count wraps from 0xFFFFFFFF to 0.
- R10: Status bit 3 sets while in the valid state with seconds equal to alarm, and stays set after the match ends. Writing 1 to a status bit clears it; writing 0 has no effect.
- R11: `irq` is status bit 3 AND control bit 7. `wake` additionally needs control bit 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Active-low asynchronous reset for both domains |
| lp_clk | input | 1 | Slow low-power counting clock |
| bus_sel | input | 1 | Register access strobe, one host cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Word address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the host cycle after the strobe |
| irq | output | 1 | Level alarm interrupt, host domain |
| wake | output | 1 | Level alarm wake request, host domain |

## Verification
Read data is due one host cycle after the strobe, so the monitor compares on the falling edge after the capturing edge. Anything that depends on a write is due up to three slow cycles plus a few host cycles after it, so the bench reads right after a write to see the old value, then waits 36 host cycles (more than three slow periods) to see the new one, and otherwise lets 64 host cycles pass after every write. Values that the free-running counter keeps changing are compared against a window computed from the elapsed slow cycles rather than an exact number. `irq` and `wake` are sampled only after that same settling time.

// File: rtl/slow_rtc.sv
module slow_rtc #(
  parameter int          SUB_W       = 15,
  parameter logic [31:0] KEY_PATTERN = 32'h41736166
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        lp_clk,
  input  logic        bus_sel,
  input  logic        bus_wr,
  input  logic [2:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        irq,
  output logic        wake
);

  localparam logic [2:0] A_SEC = 3'd0, A_SUB = 3'd1, A_ALM = 3'd2,
                         A_CTL = 3'd4, A_STS = 3'd5, A_KEY = 3'd6;
  localparam int C_INIT = 15, C_NVX = 14, C_AIE = 7, C_WKE = 4, C_CNT = 3;
  localparam int S_INIT = 15, S_NVX = 14, S_ALM = 3;
  localparam logic [15:0] CTL_MASK = 16'hC898;
  localparam logic [1:0] ST_INIT = 2'd0, ST_NV = 2'd1, ST_OK = 2'd2;

  // host side: write holding channel
  logic        h_req;
  logic [2:0]  h_addr;
  logic [31:0] h_data;
  logic [1:0]  h_ack_sync;
  logic        s_ack;
  wire         h_busy = h_req ^ h_ack_sync[1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      h_req      <= 1'b0;
      h_addr     <= '0;
      h_data     <= '0;
      h_ack_sync <= '0;
    end else begin
      h_ack_sync <= {h_ack_sync[0], s_ack};
      if (bus_sel && bus_wr && !h_busy) begin
        h_req  <= ~h_req;
        h_addr <= bus_addr;
        h_data <= bus_wdata;
      end
    end

  // slow side
  logic [2:0]       s_req_sync;
  logic [31:0]      sec, alarm, key;
  logic [SUB_W-1:0] sub;
  logic [15:0]      ctrl;
  logic             sts_init, sts_nvx, sts_alm;
  logic [1:0]       state, state_n;
  logic             s_tick;

  assign s_ack = s_req_sync[2];
  wire s_apply  = s_req_sync[2] ^ s_req_sync[1];
  wire wr_sec   = s_apply && h_addr == A_SEC;
  wire wr_alm   = s_apply && h_addr == A_ALM;
  wire wr_ctl   = s_apply && h_addr == A_CTL;
  wire wr_sts   = s_apply && h_addr == A_STS;
  wire wr_key   = s_apply && h_addr == A_KEY;
  wire [31:0] w1c = wr_sts ? h_data : 32'd0;

  wire key_ok = key == KEY_PATTERN;
  wire cnt_on = state == ST_OK && ctrl[C_CNT];
  wire match  = state == ST_OK && sec == alarm;

  always_comb begin
    state_n = state;
    case (state)
      ST_INIT: if (ctrl[C_INIT] && key_ok) state_n = ST_NV;
      ST_NV:   if (key_ok && ctrl[C_NVX]) state_n = ST_OK;
      ST_OK:   if (!key_ok) state_n = ST_NV;
      default: state_n = ST_INIT;
    endcase
  end

  wire left_init = state == ST_INIT && state_n == ST_NV;
  wire got_valid = state == ST_NV && state_n == ST_OK;
  wire lost_key  = state == ST_OK && state_n == ST_NV;

  always_ff @(posedge lp_clk or negedge rst_n)
    if (!rst_n) begin
      s_req_sync <= '0;
      s_tick     <= 1'b0;
      sec        <= '0;
      sub        <= '0;
      alarm      <= '0;
      key        <= '0;
      ctrl       <= '0;
      state      <= ST_INIT;
      sts_init   <= 1'b0;
      sts_nvx    <= 1'b0;
      sts_alm    <= 1'b0;
    end else begin
      s_req_sync <= {s_req_sync[1:0], h_req};
      s_tick     <= ~s_tick;
      state      <= state_n;
      if (wr_alm) alarm <= h_data;
      if (wr_key) key   <= h_data;
      if (wr_ctl) ctrl  <= h_data[15:0] & CTL_MASK;
      if (wr_sec) begin
        sec <= h_data;
        sub <= '0;
      end else if (cnt_on) begin
        sub <= sub + 1'b1;
        if (&sub) sec <= sec + 32'd1;
      end
      sts_init <= left_init | (sts_init & ~w1c[S_INIT]);
      sts_nvx  <= got_valid | (sts_nvx & ~w1c[S_NVX] & ~lost_key);
      sts_alm  <= match     | (sts_alm & ~w1c[S_ALM]);
    end

  wire [31:0] s_sts = {16'd0, sts_init, sts_nvx, 10'd0, sts_alm, 3'd0};

  // host side: shadow copy refreshed once per slow cycle
  logic [2:0]       h_tick_sync;
  logic [31:0]      sh_sec, sh_alm, sh_sts, sh_key;
  logic [SUB_W-1:0] sh_sub;
  logic [15:0]      sh_ctl;
  wire grab = h_tick_sync[2] ^ h_tick_sync[1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      h_tick_sync <= '0;
      sh_sec <= '0;
      sh_sub <= '0;
      sh_alm <= '0;
      sh_ctl <= '0;
      sh_sts <= '0;
      sh_key <= '0;
    end else begin
      h_tick_sync <= {h_tick_sync[1:0], s_tick};
      if (grab) begin
        sh_sec <= sec;
        sh_sub <= sub;
        sh_alm <= alarm;
        sh_ctl <= ctrl;
        sh_sts <= s_sts;
        sh_key <= key;
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) bus_rdata <= '0;
    else if (bus_sel && !bus_wr)
      case (bus_addr)
        A_SEC:   bus_rdata <= sh_sec;
        A_SUB:   bus_rdata <= {{(32-SUB_W){1'b0}}, sh_sub};
        A_ALM:   bus_rdata <= sh_alm;
        A_CTL:   bus_rdata <= {16'd0, sh_ctl};
        A_STS:   bus_rdata <= sh_sts;
        A_KEY:   bus_rdata <= sh_key;
        default: bus_rdata <= '0;
      endcase

  assign irq  = sh_sts[S_ALM] & sh_ctl[C_AIE];
  assign wake = irq & sh_ctl[C_WKE];

endmodule

// File: rtl/slow_rtc_chk.sv
module slow_rtc_chk #(
  parameter logic [31:0] KEY = 32'h41736166
) (
  input logic        lp_clk,
  input logic        rst_n,
  input logic [1:0]  state,
  input logic [31:0] key,
  input logic [31:0] sec,
  input logic        cnt_on,
  input logic        wr_sec,
  input logic        sts_alm
);
  localparam logic [1:0] ST_INIT = 2'd0, ST_NV = 2'd1, ST_OK = 2'd2;

  a_r4_init_exit_needs_key: assert property (@(posedge lp_clk) disable iff (!rst_n)
    (state != ST_INIT && $past(state) == ST_INIT) |-> $past(key) == KEY);

  a_r5_valid_only_from_nonvalid: assert property (@(posedge lp_clk) disable iff (!rst_n)
    (state == ST_OK && $past(state) != ST_OK) |-> $past(state) == ST_NV);

  a_r6_key_loss_leaves_valid: assert property (@(posedge lp_clk) disable iff (!rst_n)
    key != KEY |=> state != ST_OK);

  a_r7_seconds_frozen: assert property (@(posedge lp_clk) disable iff (!rst_n)
    (!cnt_on && !wr_sec) |=> $stable(sec));

  a_r10_flag_rises_in_valid: assert property (@(posedge lp_clk) disable iff (!rst_n)
    $rose(sts_alm) |-> $past(state) == ST_OK);
endmodule

bind slow_rtc slow_rtc_chk #(.KEY(KEY_PATTERN)) u_chk (
  .lp_clk (lp_clk),
  .rst_n  (rst_n),
  .state  (state),
  .key    (key),
  .sec    (sec),
  .cnt_on (cnt_on),
  .wr_sec (wr_sec),
  .sts_alm(sts_alm)
);

// File: tb/tb_slow_rtc.sv
module tb_slow_rtc;
  localparam logic [31:0] KEY = 32'h41736166;

  logic clk = 1'b0, lp_clk = 1'b0, rst_n = 1'b0;
  logic bus_sel = 1'b0, bus_wr = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic irq, wake;

  slow_rtc #(.SUB_W(3), .KEY_PATTERN(KEY)) dut (
    .clk(clk), .rst_n(rst_n), .lp_clk(lp_clk),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq), .wake(wake));

  always #2 clk = ~clk;
  initial begin
    #3;
    forever #20 lp_clk = ~lp_clk;
  end

  typedef struct {
    string       tag;
    logic [31:0] lo;
    logic [31:0] hi;
  } exp_t;

  exp_t exp_q[$];
  exp_t cur;
  int nvec = 0, nerr = 0;
  logic rd_seen = 1'b0;
  bit done = 1'b0;

  always @(posedge clk) rd_seen <= bus_sel && !bus_wr;

  always @(negedge clk)
    if (rd_seen && exp_q.size() > 0) begin
      cur = exp_q.pop_front();
      nvec++;
      if (bus_rdata < cur.lo || bus_rdata > cur.hi) begin
        nerr++;
        $display("FAIL %s: read %h, expected %h..%h", cur.tag, bus_rdata, cur.lo, cur.hi);
      end
    end

  task automatic rd_range(input logic [2:0] a, input logic [31:0] lo,
                          input logic [31:0] hi, input string tag);
    exp_t e;
    @(negedge clk);
    e.tag = tag; e.lo = lo; e.hi = hi;
    exp_q.push_back(e);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [31:0] v, input string tag);
    rd_range(a, v, v, tag);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic settle();
    repeat (64) @(negedge clk);
  endtask

  task automatic wrs(input logic [2:0] a, input logic [31:0] d);
    wr(a, d);
    settle();
  endtask

  task automatic chk(input string tag, input logic act, input logic expv);
    nvec++;
    if (act !== expv) begin
      nerr++;
      $display("FAIL %s: got %b, expected %b", tag, act, expv);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog: run did not complete, expected completion");
      finish_run();
    end
  end

  initial begin
    repeat (20) @(negedge clk);
    rst_n = 1'b1;
    repeat (20) @(negedge clk);

    // R1 reset state
    rd(3'd0, 0, "R1 seconds"); rd(3'd1, 0, "R1 sub");   rd(3'd2, 0, "R1 alarm");
    rd(3'd4, 0, "R1 control"); rd(3'd5, 0, "R1 status"); rd(3'd6, 0, "R1 key");
    chk("R1 irq", irq, 1'b0); chk("R1 wake", wake, 1'b0);

    // R3 write latency, R2 alarm map
    wr(3'd2, 32'h12345678);
    rd(3'd2, 32'h0, "R3 old value right after write");
    repeat (36) @(negedge clk);
    rd(3'd2, 32'h12345678, "R3 R2 alarm after three slow cycles");
    settle();

    // R2 control mask; R4 no key; R5 ignored in init; R7 not valid
    wrs(3'd4, 32'h0000FFFF);
    rd(3'd4, 32'h0000C898, "R2 control mask");
    rd(3'd5, 32'h0, "R4 no exit without key");
    rd(3'd0, 32'h0, "R7 no count before valid");

    wrs(3'd4, 32'h00004000);
    wrs(3'd6, KEY);
    rd(3'd6, KEY, "R2 key readback");
    rd(3'd5, 32'h0, "R5 non-valid exit ignored in init");
    wrs(3'd4, 32'h00008000);
    rd(3'd5, 32'h00008000, "R4 init exit done");
    wrs(3'd4, 32'h0000C000);
    rd(3'd5, 32'h0000C000, "R5 non-valid exit done");

    // R8 reload, R7 gated by enable
    wrs(3'd0, 32'h100);
    rd(3'd0, 32'h100, "R8 seconds loaded");
    rd(3'd1, 32'h0, "R8 sub cleared");
    repeat (100) @(negedge clk);
    rd(3'd0, 32'h100, "R7 count enable off");

    wrs(3'd4, 32'h0000C008);
    repeat (160) @(negedge clk);
    rd_range(3'd0, 32'h101, 32'h103, "R7 counting advances");

    wrs(3'd0, 32'h500);
    rd_range(3'd0, 32'h500, 32'h501, "R8 reload while counting");

    // R9 wrap
    wrs(3'd0, 32'hFFFFFFFF);
    repeat (100) @(negedge clk);
    rd_range(3'd0, 32'h0, 32'h1, "R9 wrap to zero");

    // R6 key loss and recovery
    wrs(3'd6, 32'h0);
    rd(3'd5, 32'h00008000, "R6 status14 cleared on key loss");
    wrs(3'd0, 32'h777);
    repeat (100) @(negedge clk);
    rd(3'd0, 32'h777, "R6 counting halted");
    wrs(3'd6, KEY);
    rd(3'd5, 32'h0000C000, "R6 valid re-entered");

    // R10 alarm flag, R11 outputs
    wrs(3'd4, 32'h0000C000);
    wrs(3'd5, 32'hFFFFFFFF);
    rd(3'd5, 32'h0, "R10 write-one clears");
    wrs(3'd0, 32'h20);
    wrs(3'd2, 32'h22);
    wrs(3'd4, 32'h0000C088);
    rd(3'd5, 32'h0, "R10 no flag before match");
    chk("R11 irq low before match", irq, 1'b0);
    repeat (200) @(negedge clk);
    rd(3'd5, 32'h8, "R10 flag on match");
    chk("R11 irq with enable", irq, 1'b1);
    chk("R11 wake needs wake enable", wake, 1'b0);
    wrs(3'd4, 32'h0000C098);
    chk("R11 wake with both enables", wake, 1'b1);
    chk("R11 irq stays", irq, 1'b1);
    wrs(3'd4, 32'h0000C010);
    chk("R11 irq gated off", irq, 1'b0);
    chk("R11 wake gated off", wake, 1'b0);
    rd(3'd5, 32'h8, "R10 flag sticky after match");
    wrs(3'd5, 32'h0);
    rd(3'd5, 32'h8, "R10 zero write no effect");
    wrs(3'd5, 32'h8);
    rd(3'd5, 32'h0, "R10 flag cleared");

    repeat (4) @(negedge clk);
    done = 1'b1;
    finish_run();
  end
endmodule